// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Swap Unit with Flag Generation

This block carries out the single-operand shift-class operations of an 8-bit processor datapath. Each cycle it takes one byte operand, the current carry flag, a 3-bit operation code and an enable. On the next rising clock edge it presents the transformed byte and the new zero, carry, negative and overflow flag values. Each flag has its own write strobe, so the surrounding status register takes only the flags that the operation defines.

Six operations are supported:

- logical shifts left and right;
- rotates left and right through the carry flag;
- arithmetic shift right;
- nibble swap.

Shifts and rotates update all four flags together. The swap writes its result but leaves every flag strobe low. When the enable is low, or the code is one of the two unused values, nothing is written. Every output is registered, so each operation has a latency of exactly one clock and a new operation can be issued every cycle.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 (logical shift left) returns the operand shifted up by one with 0 in bit 0, and the new carry is the old bit 7.
- R2: Code 1 (logical shift right) returns the operand shifted down by one with 0 in bit 7, and the new carry is the old bit 0.
- R3: Code 2 (rotate left) puts the incoming carry into bit 0 and sends old bit 7 to carry. Code 3 (rotate right) puts the incoming carry into bit 7 and sends old bit 0 to carry.
- R4: Code 4 (arithmetic shift right) keeps bit 7, moves bits 7..1 down into bits 6..0, and sends old bit 0 to carry.
- R5: For codes 0 to 4 the zero flag is 1 exactly when the 8-bit result is 0, and the negative flag equals result bit 7.
- R6: For codes 0 to 4 the overflow flag equals the negative flag XOR the new carry.
- R7: Code 5 (swap) exchanges bits 7..4 with bits 3..0 and asserts the result strobe, with all four flag strobes low. The flag outputs keep their previous values.
- R8: With the enable low, the result strobe and all flag strobes are low on the next edge, and the result and flag outputs keep their previous values.
- R9: Codes 6 and 7 write nothing: all strobes are low on the next edge and the outputs hold.
- R10: After reset, the result, the flags and all strobes are 0. An operation presented in one cycle appears on the following rising edge, and the four flag strobes always rise and fall together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation valid this cycle |
| op | input | 3 | Operation code (0 LSL, 1 LSR, 2 ROL, 3 ROR, 4 ASR, 5 SWAP) |
| opnd | input | 8 | Operand byte |
| cin | input | 1 | Current carry flag |
| result | output | 8 | Registered result byte |
| result_we | output | 1 | Result write strobe |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| z_we | output | 1 | Zero flag write strobe |
| c_we | output | 1 | Carry flag write strobe |
| n_we | output | 1 | Negative flag write strobe |
| v_we | output | 1 | Overflow flag write strobe |

## Verification
Two things can change in the same edge: a result write, and either a four-flag update or a flag hold. A swap placed directly after a flag-setting shift provokes this. The result must then change while all four flag outputs keep the values left by the shift. The bench also chains operations, feeding each rotate the carry that the previous shift produced. A scoreboard compares every output on every edge against an independent model, including outputs that must be held.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LSL  = 3'd0,
    OP_LSR  = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_ASR  = 3'd4,
    OP_SWAP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shr_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } shr_flags_t;
endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  shr_op_e      op,
  output logic [W-1:0] y,
  output logic         cout
);
  localparam int H = W / 2;

  logic [W-1:0] up_v;
  logic [W-1:0] dn_v;

  // Bit-wise shifted copies of the operand; the fill bits are chosen below.
  for (genvar i = 1; i < W; i++) begin : g_up
    assign up_v[i] = a[i-1];
  end
  for (genvar i = 0; i < W - 1; i++) begin : g_dn
    assign dn_v[i] = a[i+1];
  end

  logic fill_lo;
  logic fill_hi;

  always_comb begin
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    case (op)
      OP_ROL:  fill_lo = cin;
      OP_ROR:  fill_hi = cin;
      OP_ASR:  fill_hi = a[W-1];
      default: ;
    endcase
  end

  assign up_v[0]   = fill_lo;
  assign dn_v[W-1] = fill_hi;

  always_comb begin
    case (op)
      OP_LSL, OP_ROL:         begin y = up_v;                         cout = a[W-1]; end
      OP_LSR, OP_ROR, OP_ASR: begin y = dn_v;                         cout = a[0];   end
      OP_SWAP:                begin y = {a[H-1:0], a[W-1:H]};         cout = cin;    end
      default:                begin y = a;                            cout = cin;    end
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         en,
  input  shr_op_e      op,
  input  logic [W-1:0] y,
  input  logic         cout,
  output shr_flags_t   fl,
  output logic         res_we,
  output logic         flg_we
);
  logic is_shift;
  logic is_swap;

  always_comb begin
    is_shift = 1'b0;
    is_swap  = 1'b0;
    case (op)
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: is_shift = 1'b1;
      OP_SWAP:                                is_swap  = 1'b1;
      default: ;
    endcase
  end

  assign res_we = en & (is_shift | is_swap);
  assign flg_we = en & is_shift;

  always_comb begin
    fl.z = ~|y;
    fl.c = cout;
    fl.n = y[W-1];
    fl.v = y[W-1] ^ cout;
  end
endmodule

// File: rtl/shrot_outreg.sv
module shrot_outreg
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] y_d,
  input  shr_flags_t   fl_d,
  input  logic         res_we_d,
  input  logic         flg_we_d,
  output logic [W-1:0] y_q,
  output shr_flags_t   fl_q,
  output logic         res_we_q,
  output logic         flg_we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      y_q      <= '0;
      fl_q     <= '0;
      res_we_q <= 1'b0;
      flg_we_q <= 1'b0;
    end else begin
      res_we_q <= res_we_d;
      flg_we_q <= flg_we_d;
      if (res_we_d) y_q  <= y_d;
      if (flg_we_d) fl_q <= fl_d;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_v,
  output logic         z_we,
  output logic         c_we,
  output logic         n_we,
  output logic         v_we
);
  shr_op_e    op_e;
  logic [W-1:0] y_c;
  logic       cout_c;
  shr_flags_t fl_c;
  logic       res_we_c;
  logic       flg_we_c;
  shr_flags_t fl_q;
  logic       flg_we_q;

  assign op_e = shr_op_e'(op);

  shrot_datapath #(.W(W)) u_dp (
    .a(opnd), .cin(cin), .op(op_e), .y(y_c), .cout(cout_c)
  );

  shrot_flags #(.W(W)) u_fl (
    .en(en), .op(op_e), .y(y_c), .cout(cout_c),
    .fl(fl_c), .res_we(res_we_c), .flg_we(flg_we_c)
  );

  shrot_outreg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .y_d(y_c), .fl_d(fl_c),
    .res_we_d(res_we_c), .flg_we_d(flg_we_c),
    .y_q(result), .fl_q(fl_q), .res_we_q(result_we), .flg_we_q(flg_we_q)
  );

  assign flag_z = fl_q.z;
  assign flag_c = fl_q.c;
  assign flag_n = fl_q.n;
  assign flag_v = fl_q.v;
  assign z_we   = flg_we_q;
  assign c_we   = flg_we_q;
  assign n_we   = flg_we_q;
  assign v_we   = flg_we_q;

  // R8: an idle cycle produces no writes and holds the outputs
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!result_we && !z_we && !c_we && !n_we && !v_we
             && $stable(result) && $stable(flag_c)));

  // R7: a swap writes the result but no flag
  a_r7_swap_no_flags: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd5) |=> (result_we && !z_we && $stable(flag_z)
                            && $stable(flag_c) && $stable(flag_n) && $stable(flag_v)));

  // R9: unused codes write nothing
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (en && op[2:1] == 2'b11) |=> (!result_we && !c_we && $stable(result)));

  // R6: the overflow output tracks N xor C whenever flags are written
  a_r6_v_relation: assert property (@(posedge clk) disable iff (rst)
    v_we |-> (flag_v == (flag_n ^ flag_c)));

  // R5: the zero and negative outputs agree with the written result
  a_r5_zn_match: assert property (@(posedge clk) disable iff (rst)
    z_we |-> (flag_z == (result == '0) && flag_n == result[W-1] && result_we));

  // R10: the four flag strobes move as one group
  a_r10_strobes_grouped: assert property (@(posedge clk) disable iff (rst)
    $countones({z_we, c_we, n_we, v_we}) inside {0, 4});

  // R1: a left shift sends the old top bit to carry
  a_r1_lsl_carry: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd0) |=> (flag_c == $past(opnd[W-1]) && !result[0]));
endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] op  = 3'd0;
  logic [7:0] opnd = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] result;
  logic       result_we, flag_z, flag_c, flag_n, flag_v, z_we, c_we, n_we, v_we;

  shrot_unit dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .opnd(opnd), .cin(cin),
    .result(result), .result_we(result_we),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
    .z_we(z_we), .c_we(c_we), .n_we(n_we), .v_we(v_we)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    logic [7:0] r;
    logic       rwe;
    logic       fwe;
    logic [3:0] zcnv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  logic [7:0] m_r = 8'h00;
  logic [3:0] m_f = 4'h0;
  logic       carry_chain = 1'b0;

  task automatic drive(input logic e, input logic [2:0] o, input logic [7:0] a,
                       input logic ci, input string tag);
    logic [7:0] r;
    logic c;
    logic wr, wf;
    exp_t it;
    r = a; c = ci; wr = 1'b0; wf = 1'b0;
    if (e) begin
      case (o)
        3'd0: begin r = {a[6:0], 1'b0};   c = a[7]; wr = 1; wf = 1; end
        3'd1: begin r = {1'b0, a[7:1]};   c = a[0]; wr = 1; wf = 1; end
        3'd2: begin r = {a[6:0], ci};     c = a[7]; wr = 1; wf = 1; end
        3'd3: begin r = {ci, a[7:1]};     c = a[0]; wr = 1; wf = 1; end
        3'd4: begin r = {a[7], a[7:1]};   c = a[0]; wr = 1; wf = 1; end
        3'd5: begin r = {a[3:0], a[7:4]}; wr = 1; end
        default: ;
      endcase
    end
    if (wr) m_r = r;
    if (wf) m_f = {(r == 8'h00), c, r[7], r[7] ^ c};
    if (wf) carry_chain = c;
    it.r = m_r; it.rwe = wr; it.fwe = wf; it.zcnv = m_f; it.tag = tag;
    @(negedge clk);
    en = e; op = o; opnd = a; cin = ci;
    q.push_back(it);
  endtask

  // Monitor: compares each edge's outputs with the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        tests++;
        if (result !== it.r || result_we !== it.rwe ||
            {z_we, c_we, n_we, v_we} !== {4{it.fwe}} ||
            {flag_z, flag_c, flag_n, flag_v} !== it.zcnv) begin
          fails++;
          $display("FAIL %s: got r=%h rwe=%b we=%b%b%b%b zcnv=%b%b%b%b exp r=%h rwe=%b we=%b zcnv=%b",
                   it.tag, result, result_we, z_we, c_we, n_we, v_we,
                   flag_z, flag_c, flag_n, flag_v, it.r, it.rwe, it.fwe, it.zcnv);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if ({result, result_we, flag_z, flag_c, flag_n, flag_v, z_we, c_we, n_we, v_we} !== 17'h0) begin
      fails++;
      $display("FAIL R10 reset: got r=%h rwe=%b flags=%b%b%b%b exp all zero",
               result, result_we, flag_z, flag_c, flag_n, flag_v);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(1, 3'd0, 8'h80, 0, "R1 R5 LSL to zero");
    drive(1, 3'd0, 8'h41, 1, "R1 R6 LSL into sign");
    drive(1, 3'd1, 8'h01, 0, "R2 LSR to zero");
    drive(1, 3'd1, 8'hAA, 1, "R2 LSR even");
    drive(1, 3'd2, 8'h00, 1, "R3 ROL carry in");
    drive(1, 3'd2, 8'hC0, 0, "R3 ROL carry out");
    drive(1, 3'd3, 8'h01, 1, "R3 ROR carry in");
    drive(1, 3'd3, 8'h02, 0, "R3 ROR plain");
    drive(1, 3'd4, 8'h81, 0, "R4 ASR negative");
    drive(1, 3'd4, 8'h7F, 1, "R4 ASR positive");
    drive(1, 3'd4, 8'h01, 0, "R4 R5 ASR to zero");
    drive(1, 3'd0, 8'hFF, 0, "R6 setup");
    drive(1, 3'd5, 8'h3C, 1, "R7 swap holds flags");
    drive(1, 3'd5, 8'h00, 0, "R7 swap zero");
    drive(0, 3'd0, 8'h55, 1, "R8 idle shift");
    drive(0, 3'd5, 8'h12, 0, "R8 idle swap");
    drive(1, 3'd6, 8'h80, 0, "R9 code 6");
    drive(1, 3'd7, 8'h01, 1, "R9 code 7");
    // carry chaining: each rotate consumes the previous carry (R3, R10)
    drive(1, 3'd0, 8'h96, 0, "R10 chain start");
    for (int k = 0; k < 6; k++) drive(1, 3'd2 + 3'(k % 2), 8'h96 ^ 8'(k * 37), carry_chain, "R3 R10 chain");
    // sweep of every code over a set of patterns
    for (int o = 0; o < 8; o++) begin
      for (int p = 0; p < 12; p++) begin
        drive(1, 3'(o), 8'(p * 23 + 1), p[0], "R1 R2 R3 R4 R5 R6 R7 R9 sweep");
        if (p == 5) drive(0, 3'(o), 8'hA5, 1, "R8 sweep idle");
      end
    end
    drive(0, 3'd0, 8'h00, 0, "R8 drain");
    repeat (3) @(posedge clk);
    #3;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule